// File: doc/BRIEF.md
# Per-Line Interrupt Trigger Detector

This block turns a vector of interrupt request lines, which may change with no relation to the local clock, into a raw pending vector. Each line first passes through its own synchronizer. The line is then judged once per clock under its own three configuration bits: a level/edge select, a polarity bit and an any-edge bit. Together these bits place the line in one of five trigger modes. Level-mode lines follow their synchronized input, either directly or inverted. Edge-mode lines set a pending bit when the selected transition is seen, and the bit stays set until software removes it.

Every cell keeps the previous synchronized level of its line and updates it on every clock, whatever the mode. Software removes edge pending bits with a one-cycle clear strobe and a per-line mask. The clear never touches a line that is in level mode. If a fresh edge and a clear reach the same line in the same cycle, the edge wins. The pending vector goes on to a separate register and priority stage, which is not part of this block.

Each line's decoded trigger mode acts as the state that selects its next-pending rule. The five modes are LVL_HIGH, LVL_LOW, EDGE_RISE, EDGE_FALL and EDGE_ANY. A mode change takes effect at the next clock edge. The moves between modes are: level to edge, where the pending bit is held until an edge or a clear; edge to level, where the pending bit takes the input value; and moves between edge kinds, where only the rule for detection changes.

Top module: `irq_trigger_detect`

## Requirements
- R1: Bit i of `cfg_level` set to 1 puts line i in level mode, and set to 0 puts it in edge mode. Lines with different settings work side by side in the same vector.
- R2: In level mode, `pending[i]` equals the synchronized input when `cfg_polarity[i]`=1, and its inverse when `cfg_polarity[i]`=0.
- R3: In edge mode with `cfg_any_edge[i]`=1, any change of the synchronized input from its previous value sets `pending[i]`. This holds whatever `cfg_polarity[i]` is.
- R4: In edge mode with `cfg_any_edge[i]`=0, a 0-to-1 change sets `pending[i]` when `cfg_polarity[i]`=1, and a 1-to-0 change sets it when `cfg_polarity[i]`=0. The opposite change has no effect.
- R5: An edge-mode pending bit stays set until it is cleared.
- R6: The previous level of each line is updated every clock in every mode. A line that moves from level mode to edge mode therefore sees no edge unless its input changes after the move.
- R7: When `clr_strobe`=1, every line with `clr_mask[i]`=1 that is in edge mode has its pending bit cleared at the next edge. Level-mode lines are not affected.
- R8: While `rst_n`=0, the synchronizer flops, the previous levels and `pending` are all 0.
- R9: If a new edge and a clear hit the same line in the same cycle, `pending[i]` is 1 afterwards.
- R10: A change on `line_in` shows on `pending` after the third rising clock edge; it is not visible after the second. A configuration change takes effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | NUM_LINES | Interrupt request lines, not synchronized |
| cfg_level | input | NUM_LINES | 1 selects level mode, 0 selects edge mode |
| cfg_polarity | input | NUM_LINES | 1 = active high / rising, 0 = active low / falling |
| cfg_any_edge | input | NUM_LINES | 1 makes an edge-mode line react to both transitions |
| clr_strobe | input | 1 | One-cycle clear request |
| clr_mask | input | NUM_LINES | Lines to clear when the strobe is high |
| pending | output | NUM_LINES | Raw pending vector |

## Verification
The bench switches lines from level mode to edge mode while their inputs are held high and clears them in the same cycle. A design that did not keep tracking the previous level in level mode would then report a false rising edge. It issues a full-mask clear while lines are in level mode and while lines are in mixed modes. A design that ignored the mode would drop level bits that should follow the input. It clears in exactly the cycle a rising edge lands, which shows whether the clear wrongly wins. It also samples after the second and after the third edge to pin the synchronizer latency, and walks each edge kind against the transition it must ignore.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;

    // Decoded trigger behaviour of one line; acts as that line's state selector.
    typedef enum logic [2:0] {
        MODE_LVL_HIGH  = 3'd0,
        MODE_LVL_LOW   = 3'd1,
        MODE_EDGE_RISE = 3'd2,
        MODE_EDGE_FALL = 3'd3,
        MODE_EDGE_ANY  = 3'd4
    } trig_mode_e;

    function automatic trig_mode_e decode_mode(input logic is_level,
                                               input logic pol,
                                               input logic any_edge);
        trig_mode_e m;
        if (is_level)
            m = pol ? MODE_LVL_HIGH : MODE_LVL_LOW;
        else if (any_edge)
            m = MODE_EDGE_ANY;
        else
            m = pol ? MODE_EDGE_RISE : MODE_EDGE_FALL;
        return m;
    endfunction

    function automatic logic mode_is_level(input trig_mode_e m);
        return (m == MODE_LVL_HIGH) || (m == MODE_LVL_LOW);
    endfunction

endpackage

// File: rtl/irq_sync_chain.sv
module irq_sync_chain #(
    parameter int WIDTH  = 51,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[LAST];

endmodule

// File: rtl/irq_trig_cell.sv
module irq_trig_cell
    import irq_trig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_now,
    input  logic cfg_level,
    input  logic cfg_pol,
    input  logic cfg_any,
    input  logic clr_hit,
    output logic pend
);
    trig_mode_e mode;
    logic       prev_q;
    logic       pend_q;
    logic       pend_d;
    logic       edge_hit;

    assign mode = decode_mode(cfg_level, cfg_pol, cfg_any);

    // State register: previous level and pending bit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= lvl_now;
            pend_q <= pend_d;
        end
    end

    // Next-pending rule selected by the decoded mode.
    always_comb begin
        edge_hit = 1'b0;
        pend_d   = pend_q;
        unique case (mode)
            MODE_LVL_HIGH:  pend_d   = lvl_now;
            MODE_LVL_LOW:   pend_d   = ~lvl_now;
            MODE_EDGE_RISE: edge_hit = lvl_now & ~prev_q;
            MODE_EDGE_FALL: edge_hit = ~lvl_now & prev_q;
            MODE_EDGE_ANY:  edge_hit = lvl_now ^ prev_q;
            default:        edge_hit = 1'b0;
        endcase
        // Edge lines: a new edge beats a clear in the same cycle.
        if (!mode_is_level(mode))
            pend_d = edge_hit | (pend_q & ~clr_hit);
    end

    assign pend = pend_q;

endmodule

// File: rtl/irq_trigger_detect.sv
module irq_trigger_detect #(
    parameter int NUM_LINES   = 51,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_in,
    input  logic [NUM_LINES-1:0] cfg_level,
    input  logic [NUM_LINES-1:0] cfg_polarity,
    input  logic [NUM_LINES-1:0] cfg_any_edge,
    input  logic                 clr_strobe,
    input  logic [NUM_LINES-1:0] clr_mask,
    output logic [NUM_LINES-1:0] pending
);
    logic [NUM_LINES-1:0] line_sync;
    logic [NUM_LINES-1:0] clr_vec;

    assign clr_vec = clr_mask & {NUM_LINES{clr_strobe}};

    irq_sync_chain #(
        .WIDTH (NUM_LINES),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(line_in),
        .sync_out(line_sync)
    );

    generate
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
            irq_trig_cell u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .lvl_now  (line_sync[i]),
                .cfg_level(cfg_level[i]),
                .cfg_pol  (cfg_polarity[i]),
                .cfg_any  (cfg_any_edge[i]),
                .clr_hit  (clr_vec[i]),
                .pend     (pending[i])
            );
        end
    endgenerate

endmodule

// File: rtl/irq_trigger_detect_chk.sv
module irq_trigger_detect_chk #(
    parameter int NUM_LINES = 51
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] line_in,
    input logic [NUM_LINES-1:0] cfg_level,
    input logic [NUM_LINES-1:0] cfg_polarity,
    input logic                 clr_strobe,
    input logic [NUM_LINES-1:0] clr_mask,
    input logic [NUM_LINES-1:0] pending
);
    logic [2:0] age_q;
    logic       hist_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            age_q <= '0;
        else if (age_q != 3'd7) age_q <= age_q + 3'd1;
    end
    assign hist_ok = (age_q >= 3'd6);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (pending == '0)); // R8

    AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        hist_ok |-> (((pending ^ ($past(line_in, 3) ~^ $past(cfg_polarity)))
                      & $past(cfg_level)) == '0)); // R2

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        hist_ok |-> (($past(pending) & ~$past(cfg_level)
                      & ~($past(clr_mask) & {NUM_LINES{$past(clr_strobe)}})
                      & ~pending) == '0)); // R5

    AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        hist_ok |-> ((pending & ~$past(pending) & ~$past(cfg_level)
                      & ~($past(line_in, 3) ^ $past(line_in, 4))) == '0)); // R4

endmodule

bind irq_trigger_detect irq_trigger_detect_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_in     (line_in),
    .cfg_level   (cfg_level),
    .cfg_polarity(cfg_polarity),
    .clr_strobe  (clr_strobe),
    .clr_mask    (clr_mask),
    .pending     (pending)
);

// File: tb/test_irq_trigger_detect.sv
`timescale 1ns/1ps
module test_irq_trigger_detect;
    localparam int N = 51;
    localparam logic [N-1:0] ALL = '1;
    localparam logic [N-1:0] PA  = 51'h5A5A5_C3C3C3C3;
    localparam logic [N-1:0] PB  = 51'h3_0F0F_F00F_0FF1;
    localparam logic [N-1:0] PM  = 51'h0_0000_FFFF_0000;
    localparam logic [N-1:0] PC  = 51'h6_1234_8765_4321;
    localparam logic [N-1:0] PD  = 51'h1_FEDC_BA98_7654;
    localparam logic [N-1:0] PE  = 51'h4_0000_0001_8001;
    localparam logic [N-1:0] PL  = 51'h7_FF00_FF00_FF00;
    localparam logic [N-1:0] PG  = 51'h2_5555_AAAA_3C3C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] line_in = '0, cfg_level = '0, cfg_polarity = '0, cfg_any_edge = '0;
    logic clr_strobe = 1'b0;
    logic [N-1:0] clr_mask = '0;
    logic [N-1:0] pending;

    typedef struct {
        logic [N-1:0] exp;
        string        tag;
    } item_t;
    item_t exp_q[$];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_trigger_detect #(.NUM_LINES(N)) i_irq_trigger_detect (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .cfg_level(cfg_level),
        .cfg_polarity(cfg_polarity), .cfg_any_edge(cfg_any_edge),
        .clr_strobe(clr_strobe), .clr_mask(clr_mask), .pending(pending)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_now(input logic [N-1:0] e, input string tag);
        item_t it;
        it.exp = e;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic clr_pulse(input logic [N-1:0] m);
        clr_strobe = 1'b1;
        clr_mask   = m;
        @(negedge clk);
        clr_strobe = 1'b0;
        clr_mask   = '0;
    endtask

    // Monitor: pops expected items and compares away from the clock edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                checks++;
                if (pending !== it.exp) begin
                    errors++;
                    $display("FAIL %s: pending=%h expected=%h", it.tag, pending, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: pending=%h expected=completion", pending);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(2);
        expect_now('0, "R8 in reset");
        rst_n = 1'b1;
        step(3);
        expect_now('0, "R8 after release");

        // Level mode, active high then active low
        cfg_level = ALL; cfg_polarity = ALL; line_in = PA;
        step(2);
        expect_now('0, "R10 not yet after two edges");
        step(1);
        expect_now(PA, "R2 R10 level high after three edges");
        cfg_polarity = '0;
        step(1);
        expect_now(~PA, "R2 R10 level low, config next edge");
        clr_pulse(ALL);
        expect_now(~PA, "R7 clear ignored in level mode");

        // Level -> edge rise with inputs held; previous level tracked
        cfg_level = '0; cfg_polarity = ALL; cfg_any_edge = '0;
        clr_pulse(ALL);
        expect_now('0, "R6 switch and clear");
        step(3);
        expect_now('0, "R6 no false edge after mode switch");

        // Rising edges
        line_in = '0;
        step(3);
        expect_now('0, "R4 falling ignored in rise mode");
        line_in = PB;
        step(3);
        expect_now(PB, "R4 rising detected");
        line_in = '0;
        step(3);
        expect_now(PB, "R5 sticky after input drops");
        clr_pulse(PM);
        expect_now(PB & ~PM, "R7 partial mask clear");
        clr_pulse(ALL);
        expect_now('0, "R7 full clear");

        // Falling edges
        cfg_polarity = '0;
        line_in = PC;
        step(3);
        expect_now('0, "R4 rising ignored in fall mode");
        line_in = '0;
        step(3);
        expect_now(PC, "R4 falling detected");
        clr_pulse(ALL);
        expect_now('0, "R7 clear after fall");

        // Both edges
        cfg_any_edge = ALL;
        line_in = PD;
        step(3);
        expect_now(PD, "R3 any-edge rising");
        clr_pulse(ALL);
        expect_now('0, "R3 cleared");
        line_in = '0;
        step(3);
        expect_now(PD, "R3 any-edge falling");
        clr_pulse(ALL);
        expect_now('0, "R3 cleared again");

        // Edge and clear in the same cycle
        cfg_any_edge = '0; cfg_polarity = ALL;
        line_in = PE;
        step(2);
        clr_pulse(ALL);
        expect_now(PE, "R9 edge wins over clear");

        // Mixed modes side by side
        cfg_level = PL;
        step(1);
        expect_now(PE, "R1 mixed modes hold/follow");
        clr_pulse(ALL);
        expect_now(PE & PL, "R1 R7 clear only edge lines");
        line_in = '0;
        step(3);
        expect_now('0, "R1 level lines follow low");
        line_in = PG;
        step(3);
        expect_now(PG, "R1 level follow and edge rise together");

        step(2);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule